// File: doc/BRIEF.md
# Block-Protect Region Codec

This block translates between the block-protect field setting of a serial flash status register and the address range that setting protects, in both directions. A decode request takes a protect-level code, a low-end select bit, an invert bit and a sector-lock bit. It returns the protected window as a byte offset and a byte size. It also tells whether a query window lies entirely inside that protected window. An encode request takes a byte window that must be anchored at one end of the flash. It returns the protect-level code and the low-end and invert bits that describe the window. When no setting can describe the window, it raises an error instead. The flash size (`2**FLASH_LOG2` bytes) and the protection granularity (`2**GRAN_LOG2` bytes) are parameters, and every byte quantity is 32 bits wide.

The block runs a three-state machine. `ST_IDLE` waits for a request. A decode start moves it to `ST_DEC` (transition IDLE→DEC), and a lone encode start moves it to `ST_ENC` (IDLE→ENC). Decode has priority when both starts are raised together. From either evaluation state the machine returns to `ST_IDLE` unconditionally (DEC→IDLE, ENC→IDLE). On that return it registers the result and raises `res_valid` for exactly one cycle. While no start is raised it stays in `ST_IDLE` (IDLE→IDLE). Operands are captured in the cycle the request is accepted.

Top module: `bpr_codec`

## Requirements
- R1: With invert clear, a decode reports size 0 for level code 0. For any other code L, it reports `2**GRAN_LOG2 << (L-1)`, limited to the flash size.
- R2: With the invert bit set, the decoded size is the flash size minus the R1 size, and the low-end select is inverted before the offset is formed.
- R3: The decoded offset is 0 when the effective low-end select is 1. Otherwise it is the flash size minus the decoded size.
- R4: When the level field is 3 bits wide, a set sector-lock bit makes the decode fail. The result then has `res_err`=1, offset 0, size 0 and covered 0. With a 4-bit field the sector-lock input has no effect.
- R5: `res_covered` is 1 only when the decoded size is nonzero, the query offset is at or above the decoded offset, and query offset plus query size is at or below decoded offset plus decoded size. The sums are taken without wrap.
- R6: An encode window that neither starts at 0 (and fits in the flash) nor ends exactly at the flash size gives `res_err`=1 with code, low-end and invert all 0.
- R7: An encode sets the low-end bit when the window starts at 0. If the window size exceeds half the flash size, the invert bit is set, the size becomes the flash size minus the window size, and the low-end bit is flipped.
- R8: After R7, a size of 0 encodes as code 0. A power-of-two size at or above the granularity encodes as `log2(size) - GRAN_LOG2 + 1`. Any other size gives `res_err`=1 with code, low-end and invert all 0.
- R9: When the R8 code exceeds the largest value the level field can hold, `res_err` is 1 and the code output is all ones. The low-end and invert bits are kept.
- R10: A request accepted at clock edge k gives `res_valid`=1 for exactly the one cycle after edge k+1. `res_kind` is 0 for decode and 1 for encode. When both starts are raised together, only the decode is performed.
- R11: Starts raised while the machine is in `ST_DEC` or `ST_ENC` are ignored and produce no result.
- R12: After reset, `res_valid` and every result field are 0. The fields that belong to the path not just run read 0 in every result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_start | input | 1 | Request a decode (wins over encode) |
| dec_level | input | BP_W | Protect-level code |
| dec_low | input | 1 | Low-end select (1: window at offset 0) |
| dec_inv | input | 1 | Invert the protected window |
| dec_seclk | input | 1 | Sector-lock bit (3-bit-field parts only) |
| qry_off | input | 32 | Query window byte offset |
| qry_size | input | 32 | Query window byte size |
| enc_start | input | 1 | Request an encode |
| enc_off | input | 32 | Requested window byte offset |
| enc_size | input | 32 | Requested window byte size |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 1 | 0 decode result, 1 encode result |
| res_err | output | 1 | Setting or window not representable |
| res_off | output | 32 | Decoded window offset |
| res_size | output | 32 | Decoded window size |
| res_covered | output | 1 | Query window fully protected |
| res_level | output | BP_W | Encoded protect-level code |
| res_low | output | 1 | Encoded low-end select |
| res_inv | output | 1 | Encoded invert bit |

## Verification
The assertions assume `FLASH_LOG2` is at most 31 and `GRAN_LOG2` is below `FLASH_LOG2`, so the flash size and every limited shift fit in 32 bits. The end-anchoring and empty-window checks on decode results rely on this. The stimulus stays inside these limits by using a 1 MiB flash with granularities of 4 KiB and 64 KiB. It also keeps query windows small enough that offset plus size stays within 33 bits. Requests are issued from idle, one at a time. Stray starts are placed only in the evaluation cycle, which is the cycle in which R11 promises to drop them.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEC  = 2'd1,
        ST_ENC  = 2'd2
    } bpr_state_e;
endpackage

// File: rtl/bpr_decode.sv
module bpr_decode
    import bpr_pkg::*;
#(
    parameter int FLASH_LOG2 = 24,
    parameter int GRAN_LOG2  = 16,
    parameter int BP_W       = 3
) (
    input  logic [BP_W-1:0]   level,
    input  logic              low,
    input  logic              inv,
    input  logic              seclk,
    input  logic [ADDR_W-1:0] q_off,
    input  logic [ADDR_W-1:0] q_size,
    output logic [ADDR_W-1:0] w_off,
    output logic [ADDR_W-1:0] w_size,
    output logic              covered,
    output logic              err
);
    localparam logic [ADDR_W-1:0] FLASH = ADDR_W'(1) << FLASH_LOG2;

    logic              seclk_live;
    logic [ADDR_W-1:0] raw_sz, eff_sz, eff_off;
    logic              eff_low;
    logic [ADDR_W:0]   w_end, q_end;
    int                shamt;

    // the sector-lock bit exists only on parts with a 3-bit level field
    generate
        if (BP_W == 3) begin : g_seclk
            assign seclk_live = seclk;
        end else begin : g_noseclk
            assign seclk_live = seclk & 1'b0;
        end
    endgenerate

    always_comb begin
        shamt  = GRAN_LOG2 + int'(level) - 1;
        raw_sz = '0;
        if (level != '0) begin
            if (shamt >= FLASH_LOG2) raw_sz = FLASH;
            else                     raw_sz = ADDR_W'(1) << shamt;
        end
        if (inv) begin
            eff_sz  = FLASH - raw_sz;
            eff_low = ~low;
        end else begin
            eff_sz  = raw_sz;
            eff_low = low;
        end
        eff_off = eff_low ? '0 : FLASH - eff_sz;
        err     = seclk_live;
        w_off   = err ? '0 : eff_off;
        w_size  = err ? '0 : eff_sz;
        w_end   = {1'b0, eff_off} + {1'b0, eff_sz};
        q_end   = {1'b0, q_off} + {1'b0, q_size};
        covered = !err && (eff_sz != '0) && (q_off >= eff_off) && (q_end <= w_end);
    end
endmodule

// File: rtl/bpr_encode.sv
module bpr_encode
    import bpr_pkg::*;
#(
    parameter int FLASH_LOG2 = 24,
    parameter int GRAN_LOG2  = 16,
    parameter int BP_W       = 3
) (
    input  logic [ADDR_W-1:0] r_off,
    input  logic [ADDR_W-1:0] r_size,
    output logic [BP_W-1:0]   level,
    output logic              low,
    output logic              inv,
    output logic              err
);
    localparam logic [ADDR_W-1:0] FLASH  = ADDR_W'(1) << FLASH_LOG2;
    localparam logic [ADDR_W-1:0] HALF   = FLASH >> 1;
    localparam logic [ADDR_W-1:0] GRAN   = ADDR_W'(1) << GRAN_LOG2;
    localparam int                LV_MAX = (1 << BP_W) - 1;

    logic [ADDR_W:0]   r_end;
    logic              at_lo, at_hi, pow2;
    logic [ADDR_W-1:0] sz;
    logic              t, c;
    int                lg, code;

    always_comb begin
        r_end = {1'b0, r_off} + {1'b0, r_size};
        at_lo = (r_off == '0) && (r_size <= FLASH);
        at_hi = (r_end == {1'b0, FLASH});
        t     = (r_off == '0);
        c     = 1'b0;
        sz    = r_size;
        if (r_size > HALF) begin
            c  = 1'b1;
            sz = FLASH - r_size;
            t  = ~t;
        end
        pow2 = (sz != '0) && ((sz & (sz - ADDR_W'(1))) == '0);
        lg   = 0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (sz[i]) lg = i;
        end
        code  = lg - GRAN_LOG2 + 1;
        level = '0;
        low   = 1'b0;
        inv   = 1'b0;
        err   = 1'b0;
        if (!(at_lo || at_hi)) begin
            err = 1'b1;
        end else if (sz == '0) begin
            low = t;
            inv = c;
        end else if (pow2 && (sz >= GRAN)) begin
            low = t;
            inv = c;
            if (code > LV_MAX) begin
                err   = 1'b1;
                level = '1;
            end else begin
                level = BP_W'(code);
            end
        end else begin
            err = 1'b1;
        end
    end
endmodule

// File: rtl/bpr_codec.sv
module bpr_codec
    import bpr_pkg::*;
#(
    parameter int FLASH_LOG2 = 24,
    parameter int GRAN_LOG2  = 16,
    parameter int BP_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_start,
    input  logic [BP_W-1:0]   dec_level,
    input  logic              dec_low,
    input  logic              dec_inv,
    input  logic              dec_seclk,
    input  logic [ADDR_W-1:0] qry_off,
    input  logic [ADDR_W-1:0] qry_size,
    input  logic              enc_start,
    input  logic [ADDR_W-1:0] enc_off,
    input  logic [ADDR_W-1:0] enc_size,
    output logic              res_valid,
    output logic              res_kind,
    output logic              res_err,
    output logic [ADDR_W-1:0] res_off,
    output logic [ADDR_W-1:0] res_size,
    output logic              res_covered,
    output logic [BP_W-1:0]   res_level,
    output logic              res_low,
    output logic              res_inv
);
    bpr_state_e state, state_nx;

    logic [BP_W-1:0]   op_level;
    logic              op_low, op_inv, op_seclk;
    logic [ADDR_W-1:0] op_qoff, op_qsize, op_eoff, op_esize;

    logic [ADDR_W-1:0] d_off, d_size;
    logic              d_cov, d_err;
    logic [BP_W-1:0]   e_level;
    logic              e_low, e_inv, e_err;

    bpr_decode #(.FLASH_LOG2(FLASH_LOG2), .GRAN_LOG2(GRAN_LOG2), .BP_W(BP_W)) u_dec (
        .level(op_level), .low(op_low), .inv(op_inv), .seclk(op_seclk),
        .q_off(op_qoff), .q_size(op_qsize),
        .w_off(d_off), .w_size(d_size), .covered(d_cov), .err(d_err)
    );

    bpr_encode #(.FLASH_LOG2(FLASH_LOG2), .GRAN_LOG2(GRAN_LOG2), .BP_W(BP_W)) u_enc (
        .r_off(op_eoff), .r_size(op_esize),
        .level(e_level), .low(e_low), .inv(e_inv), .err(e_err)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (dec_start)      state_nx = ST_DEC;
                else if (enc_start) state_nx = ST_ENC;
            end
            ST_DEC:  state_nx = ST_IDLE;
            ST_ENC:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // operands are latched only when a request is accepted from idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_level <= '0;
            op_low   <= 1'b0;
            op_inv   <= 1'b0;
            op_seclk <= 1'b0;
            op_qoff  <= '0;
            op_qsize <= '0;
            op_eoff  <= '0;
            op_esize <= '0;
        end else if (state == ST_IDLE && (dec_start || enc_start)) begin
            op_level <= dec_level;
            op_low   <= dec_low;
            op_inv   <= dec_inv;
            op_seclk <= dec_seclk;
            op_qoff  <= qry_off;
            op_qsize <= qry_size;
            op_eoff  <= enc_off;
            op_esize <= enc_size;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_kind    <= 1'b0;
            res_err     <= 1'b0;
            res_off     <= '0;
            res_size    <= '0;
            res_covered <= 1'b0;
            res_level   <= '0;
            res_low     <= 1'b0;
            res_inv     <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            unique case (state)
                ST_IDLE: ;
                ST_DEC: begin
                    res_valid   <= 1'b1;
                    res_kind    <= 1'b0;
                    res_err     <= d_err;
                    res_off     <= d_off;
                    res_size    <= d_size;
                    res_covered <= d_cov;
                    res_level   <= '0;
                    res_low     <= 1'b0;
                    res_inv     <= 1'b0;
                end
                ST_ENC: begin
                    res_valid   <= 1'b1;
                    res_kind    <= 1'b1;
                    res_err     <= e_err;
                    res_off     <= '0;
                    res_size    <= '0;
                    res_covered <= 1'b0;
                    res_level   <= e_level;
                    res_low     <= e_low;
                    res_inv     <= e_inv;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bpr_codec_chk.sv
module bpr_codec_chk
    import bpr_pkg::*;
#(
    parameter int FLASH_LOG2 = 24
) (
    input logic              clk,
    input logic              rst_n,
    input bpr_state_e        state,
    input logic              res_valid,
    input logic              res_kind,
    input logic              res_err,
    input logic [ADDR_W-1:0] res_off,
    input logic [ADDR_W-1:0] res_size,
    input logic              res_covered
);
    localparam logic [ADDR_W:0] FLASH_X = (ADDR_W+1)'(1) << FLASH_LOG2;

    a_r10_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r10_eval_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> res_valid);

    a_r10_result_from_eval: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(state) != ST_IDLE));

    a_r11_eval_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE));

    a_r3_window_anchored: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_kind && !res_err) |->
            (res_off == '0 || ({1'b0, res_off} + {1'b0, res_size}) == FLASH_X));

    a_r5_empty_not_covered: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_kind && res_size == '0) |-> !res_covered);

    a_r4_error_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_kind && res_err) |-> (res_size == '0 && res_off == '0 && !res_covered));
endmodule

bind bpr_codec bpr_codec_chk #(.FLASH_LOG2(FLASH_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state),
    .res_valid(res_valid), .res_kind(res_kind), .res_err(res_err),
    .res_off(res_off), .res_size(res_size), .res_covered(res_covered)
);

// File: tb/bpr_codec_tb.sv
module bpr_codec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FL = 20;
    localparam int GL = 12;
    localparam longint FSZ = longint'(1) << FL;
    localparam longint GSZ = longint'(1) << GL;

    typedef struct packed {
        logic        kind;
        logic        err;
        logic [31:0] off;
        logic [31:0] size;
        logic        cov;
        logic [2:0]  lvl;
        logic        low;
        logic        inv;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        dec_start = 0, dec_low = 0, dec_inv = 0, dec_seclk = 0, enc_start = 0;
    logic [2:0]  dec_level = 0;
    logic [31:0] qry_off = 0, qry_size = 0, enc_off = 0, enc_size = 0;
    logic        res_valid, res_kind, res_err, res_covered, res_low, res_inv;
    logic [31:0] res_off, res_size;
    logic [2:0]  res_level;

    bpr_codec #(.FLASH_LOG2(FL), .GRAN_LOG2(GL), .BP_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .dec_start(dec_start), .dec_level(dec_level), .dec_low(dec_low),
        .dec_inv(dec_inv), .dec_seclk(dec_seclk),
        .qry_off(qry_off), .qry_size(qry_size),
        .enc_start(enc_start), .enc_off(enc_off), .enc_size(enc_size),
        .res_valid(res_valid), .res_kind(res_kind), .res_err(res_err),
        .res_off(res_off), .res_size(res_size), .res_covered(res_covered),
        .res_level(res_level), .res_low(res_low), .res_inv(res_inv)
    );

    // second instance with coarse granularity so the size limit is reachable
    logic        c_start = 0;
    logic [2:0]  c_level = 0;
    logic        c_valid, c_kind, c_err, c_cov, c_low, c_inv;
    logic [31:0] c_off, c_size;
    logic [2:0]  c_lvl;

    bpr_codec #(.FLASH_LOG2(FL), .GRAN_LOG2(16), .BP_W(3)) u_clip (
        .clk(clk), .rst_n(rst_n),
        .dec_start(c_start), .dec_level(c_level), .dec_low(1'b0),
        .dec_inv(1'b0), .dec_seclk(1'b0),
        .qry_off(32'd0), .qry_size(32'd0),
        .enc_start(1'b0), .enc_off(32'd0), .enc_size(32'd0),
        .res_valid(c_valid), .res_kind(c_kind), .res_err(c_err),
        .res_off(c_off), .res_size(c_size), .res_covered(c_cov),
        .res_level(c_lvl), .res_low(c_low), .res_inv(c_inv)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    function automatic exp_t model_dec(logic [2:0] lv, logic lo, logic iv, logic sk,
                                       logic [31:0] qo, logic [31:0] qs);
        exp_t   e = '0;
        longint raw, sz, off;
        logic   t;
        e.kind = 1'b0;
        if (sk) begin
            e.err = 1'b1;
            return e;
        end
        raw = (lv == 0) ? 0 : (GSZ << (lv - 1));
        if (raw > FSZ) raw = FSZ;
        sz = iv ? FSZ - raw : raw;
        t  = iv ? ~lo : lo;
        off = t ? 0 : FSZ - sz;
        e.off  = 32'(off);
        e.size = 32'(sz);
        e.cov  = (sz != 0) && (longint'(qo) >= off) && (longint'(qo) + longint'(qs) <= off + sz);
        return e;
    endfunction

    function automatic exp_t model_enc(logic [31:0] o, logic [31:0] s);
        exp_t   e = '0;
        longint lo = longint'(o), ls = longint'(s), sz;
        logic   t, c;
        int     lg, code;
        e.kind = 1'b1;
        if (!((lo == 0 && ls <= FSZ) || lo + ls == FSZ)) begin
            e.err = 1'b1;
            return e;
        end
        t = (lo == 0); c = 1'b0; sz = ls;
        if (ls > FSZ / 2) begin
            c = 1'b1; sz = FSZ - ls; t = ~t;
        end
        if (sz == 0) begin
            e.low = t; e.inv = c;
        end else if ((sz & (sz - 1)) == 0 && sz >= GSZ) begin
            lg = 0;
            while ((longint'(1) << lg) < sz) lg++;
            code = lg - GL + 1;
            e.low = t; e.inv = c;
            if (code > 7) begin
                e.err = 1'b1; e.lvl = 3'd7;
            end else begin
                e.lvl = 3'(code);
            end
        end else begin
            e.err = 1'b1;
        end
        return e;
    endfunction

    task automatic drive(input logic ds, input logic es, input logic stray,
                         input logic [2:0] lv, input logic lo, input logic iv, input logic sk,
                         input logic [31:0] qo, input logic [31:0] qs,
                         input logic [31:0] eo, input logic [31:0] esz, input string tag);
        @(negedge clk);
        dec_level = lv; dec_low = lo; dec_inv = iv; dec_seclk = sk;
        qry_off = qo; qry_size = qs; enc_off = eo; enc_size = esz;
        dec_start = ds; enc_start = es;
        exp_q.push_back(ds ? model_dec(lv, lo, iv, sk, qo, qs) : model_enc(eo, esz));
        tag_q.push_back(tag);
        @(negedge clk);
        dec_start = 0; enc_start = 0;
        if (stray) begin
            dec_start = 1; enc_start = 1;
            dec_level = 3'd5; dec_seclk = 1'b1; enc_off = 32'h1234; enc_size = 32'h10;
        end
        @(negedge clk);
        dec_start = 0; enc_start = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t  got, e;
            string t;
            got = {res_kind, res_err, res_off, res_size, res_covered, res_level, res_low, res_inv};
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected result got=%h expected=none", got);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (got !== e) begin
                    n_fail++;
                    $display("FAIL %s got=%h expected=%h", t, got, e);
                end
            end
        end
    end

    task automatic clip_check(input logic [2:0] lv, input logic [31:0] want);
        @(negedge clk);
        c_level = lv; c_start = 1;
        @(negedge clk);
        c_start = 0;
        @(negedge clk);
        n_checks++;
        if (!(c_valid === 1'b1 && c_size === want && c_err === 1'b0)) begin
            n_fail++;
            $display("FAIL R1 limit level=%0d got valid=%b size=%h expected valid=1 size=%h",
                     lv, c_valid, c_size, want);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog got=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        n_checks++;
        if (!(res_valid === 1'b0 && res_off === 0 && res_size === 0 && res_level === 0
              && res_err === 1'b0 && res_covered === 1'b0)) begin
            n_fail++;
            $display("FAIL R12 reset got valid=%b off=%h size=%h lvl=%0d expected all zero",
                     res_valid, res_off, res_size, res_level);
        end
        // decode path
        drive(1, 0, 0, 3'd0, 0, 0, 0, 32'h0, 32'h10, 0, 0, "R1 level zero");
        drive(1, 0, 0, 3'd3, 0, 0, 0, 32'hFD000, 32'h1000, 0, 0, "R3 high window covered");
        drive(1, 0, 0, 3'd3, 1, 0, 0, 32'h3000, 32'h2000, 0, 0, "R5 query overruns window");
        drive(1, 0, 0, 3'd7, 1, 0, 0, 32'h0, 32'h40000, 0, 0, "R1 top level");
        drive(1, 0, 0, 3'd2, 0, 1, 0, 32'h0, 32'hFE000, 0, 0, "R2 inverted window");
        drive(1, 0, 0, 3'd2, 1, 1, 0, 32'h1000, 32'h1000, 0, 0, "R2 R5 query below inverted");
        drive(1, 0, 0, 3'd4, 1, 0, 1, 32'h0, 32'h10, 0, 0, "R4 sector lock");
        // encode path
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h8000, "R8 R7 low window");
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 32'hF0000, 32'h10000, "R8 high window");
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h0, 32'hC0000, "R7 over half");
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h80000, 32'h80000, "R9 code overflow");
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h3000, "R8 not power of two");
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h800, "R8 below granularity");
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h1000, 32'h1000, "R6 unanchored");
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h100000, "R7 whole flash");
        drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0, "R8 empty window");
        // priority and stray starts
        drive(1, 1, 0, 3'd1, 0, 0, 0, 32'hFF000, 32'h1000, 32'h0, 32'h8000, "R10 decode wins");
        drive(1, 0, 1, 3'd1, 1, 0, 0, 32'h0, 32'h1000, 0, 0, "R11 stray during decode");
        drive(0, 1, 1, 0, 0, 0, 0, 0, 0, 32'hFC000, 32'h4000, "R11 stray during encode");
        // limit against flash size
        clip_check(3'd4, 32'h80000);
        clip_check(3'd5, 32'h100000);
        clip_check(3'd6, 32'h100000);
        repeat (4) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 missing results got=%0d pending expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule